// File: doc/BRIEF.md
# Flash Program/Erase Guard

This block sits between the CPU-side control registers and an embedded flash array and decides, cycle by cycle, whether the array may be programmed or erased. Three protection layers are stacked. A hardware layer returns every register to zero and forces all mode outputs low on asynchronous reset, on a watchdog reset pulse, or while standby is requested. A software layer needs a write-enable bit before a program or erase request takes effect, and it uses a 16-bit block mask to choose which blocks may receive an erase strobe. An error layer watches CPU activity that is illegal during an operation. When such activity occurs, it aborts the operation and latches a sticky error flag.

Software writes a control register to request an operation and writes two mask registers to select the blocks to erase. The flash timing engine consumes `prog_mode_o`, `erase_mode_o` and `erase_stb_o`. The CPU reads the error flag back through the same register port. Cell timing and verify sequencing are outside this block.

Top module: `flash_guard`

## Requirements
- R1: Asynchronous reset, a `wdt_rst_i` pulse or `standby_i` each clear the control register, both mask registers and the error flag on the next clock edge. While `wdt_rst_i` or `standby_i` is high, `prog_mode_o`, `erase_mode_o` and every `erase_stb_o` bit are low in the same cycle.
- R2: Register map: address 0 is control, with write-enable in bit 0, program request in bit 1 and erase request in bit 2. Address 2 is the mask for blocks 0..7 and address 3 is the mask for blocks 8..15. Each reads back the value written, and `rdata_o` follows `addr_i` combinationally.
- R3: While the write-enable bit is 0, neither `prog_mode_o` nor `erase_mode_o` is ever high, whatever the request bits hold.
- R4: `prog_mode_o` is high when write-enable and the program request are 1, the erase request is 0 and the error flag is 0. `erase_mode_o` is high under the same conditions with the two request bits swapped. When both request bits are 1, neither mode is entered.
- R5: `erase_stb_o[i]` equals `erase_mode_o` AND mask bit i. With an all-zero mask, no block is ever strobed.
- R6: A pulse on `flash_rd_i`, `exc_start_i`, `sleep_i` or `bus_rel_i` while a mode is active has four effects at the next edge. It sets the error flag (address 1, bit 7) and clears both request bits. It leaves write-enable unchanged. Both modes are low from then on.
- R7: The error flag stays set until an R1 clear. While it is set, no mode is entered even after the requests are rewritten. Writes to address 1 have no effect.
- R8: An event input pulsed while no mode is active does not set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wdt_rst_i | input | 1 | Watchdog reset pulse, synchronous clear |
| standby_i | input | 1 | Standby request, synchronous clear and output block |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |
| flash_rd_i | input | 1 | CPU read of the flash array, including fetches |
| exc_start_i | input | 1 | Non-reset exception entry |
| sleep_i | input | 1 | Sleep instruction executed |
| bus_rel_i | input | 1 | CPU released the bus |
| prog_mode_o | output | 1 | Program mode active |
| erase_mode_o | output | 1 | Erase mode active |
| erase_stb_o | output | 16 | Per-block erase strobe |
| err_o | output | 1 | Sticky error flag |

## Verification
The assertions assume that every event, clear and write input is synchronous to `clk_i` and settles before the rising edge. They also take a single high cycle to be one occurrence of that event. The bench changes all of these inputs only on the falling edge and raises at most one event line at a time, so each abort can be attributed to one cause. It holds a write strobe for exactly one cycle and samples between edges. It never overlaps a register write with a clear, so the ordering checked is always that of a single stimulus.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int CTRL_WEN  = 0;
  localparam int CTRL_PRG  = 1;
  localparam int CTRL_ERS  = 2;
  localparam int STAT_ERR  = 7;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_BLK0 = 2;
  localparam int NUM_EVT   = 4;

  typedef struct packed {
    logic ers;
    logic prg;
    logic wen;
  } ctrl_t;
endpackage

// File: rtl/fg_regs.sv
module fg_regs
  import flash_guard_pkg::*;
#(
  parameter int REG_W        = 8,
  parameter int NUM_BLK_REGS = 2,
  parameter int ADDR_W       = 2,
  localparam int NUM_BLKS    = REG_W * NUM_BLK_REGS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                hw_clr_i,
  input  logic                abort_i,
  input  logic                err_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  output ctrl_t               ctrl_o,
  output logic [NUM_BLKS-1:0] mask_o
);
  ctrl_t               ctrl_q;
  logic [NUM_BLKS-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (hw_clr_i) begin
      ctrl_q <= '0;
    end else begin
      if (we_i && addr_i == ADDR_W'(ADDR_CTRL)) begin
        ctrl_q.wen <= wdata_i[CTRL_WEN];
        ctrl_q.prg <= wdata_i[CTRL_PRG];
        ctrl_q.ers <= wdata_i[CTRL_ERS];
      end
      // abort wins over a same-cycle request write
      if (abort_i) begin
        ctrl_q.prg <= 1'b0;
        ctrl_q.ers <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (hw_clr_i) begin
      mask_q <= '0;
    end else if (we_i) begin
      for (int k = 0; k < NUM_BLK_REGS; k++) begin
        if (addr_i == ADDR_W'(ADDR_BLK0 + k)) mask_q[k*REG_W +: REG_W] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CTRL)) begin
      rdata_o[CTRL_WEN] = ctrl_q.wen;
      rdata_o[CTRL_PRG] = ctrl_q.prg;
      rdata_o[CTRL_ERS] = ctrl_q.ers;
    end else if (addr_i == ADDR_W'(ADDR_STAT)) begin
      rdata_o[STAT_ERR] = err_i;
    end else begin
      for (int k = 0; k < NUM_BLK_REGS; k++) begin
        if (addr_i == ADDR_W'(ADDR_BLK0 + k)) rdata_o = mask_q[k*REG_W +: REG_W];
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign mask_o = mask_q;

  // R1
  hw_clr_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_clr_i |=> (ctrl_q == '0 && mask_q == '0));
  // R6
  abort_clears_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!ctrl_q.prg && !ctrl_q.ers));
endmodule

// File: rtl/fg_err_mon.sv
module fg_err_mon
  import flash_guard_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hw_clr_i,
  input  logic               op_active_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               abort_o,
  output logic               err_o
);
  logic err_q;

  assign abort_o = op_active_i && (|evt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_q <= 1'b0;
    else if (hw_clr_i) err_q <= 1'b0;
    else if (abort_o)  err_q <= 1'b1;
  end

  assign err_o = err_q;

  // R6
  evt_sets_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_active_i && (|evt_i) && !hw_clr_i) |=> err_q);
  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !hw_clr_i) |=> err_q);
  // R8
  idle_evt_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!op_active_i && !err_q) |=> !err_q);
endmodule

// File: rtl/fg_mode_gate.sv
module fg_mode_gate
  import flash_guard_pkg::*;
#(
  parameter int NUM_BLKS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  ctrl_t               ctrl_i,
  input  logic                err_i,
  input  logic                hw_clr_i,
  input  logic [NUM_BLKS-1:0] mask_i,
  output logic                prog_mode_o,
  output logic                erase_mode_o,
  output logic [NUM_BLKS-1:0] erase_stb_o
);
  logic allow;

  assign allow        = ctrl_i.wen && !err_i && !hw_clr_i;
  assign prog_mode_o  = allow && ctrl_i.prg && !ctrl_i.ers;
  assign erase_mode_o = allow && ctrl_i.ers && !ctrl_i.prg;

  for (genvar b = 0; b < NUM_BLKS; b++) begin : g_stb
    assign erase_stb_o[b] = erase_mode_o && mask_i[b];
  end

  // R5
  stb_needs_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_stb_o & ~mask_i) == '0);
  // R3
  wen_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.wen |-> (!prog_mode_o && !erase_mode_o));
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int REG_W        = 8,
  parameter int NUM_BLK_REGS = 2,
  parameter int ADDR_W       = $clog2(NUM_BLK_REGS + 2),
  parameter int NUM_BLKS     = REG_W * NUM_BLK_REGS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wdt_rst_i,
  input  logic                standby_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic                flash_rd_i,
  input  logic                exc_start_i,
  input  logic                sleep_i,
  input  logic                bus_rel_i,
  output logic                prog_mode_o,
  output logic                erase_mode_o,
  output logic [NUM_BLKS-1:0] erase_stb_o,
  output logic                err_o
);
  logic                hw_clr;
  logic                abort;
  logic                err;
  ctrl_t               ctrl;
  logic [NUM_BLKS-1:0] mask;
  logic [NUM_EVT-1:0]  evt;

  assign hw_clr = wdt_rst_i || standby_i;
  assign evt    = {bus_rel_i, sleep_i, exc_start_i, flash_rd_i};

  fg_regs #(
    .REG_W(REG_W), .NUM_BLK_REGS(NUM_BLK_REGS), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk_i, .rst_ni, .hw_clr_i(hw_clr), .abort_i(abort), .err_i(err),
    .we_i, .addr_i, .wdata_i, .rdata_o, .ctrl_o(ctrl), .mask_o(mask)
  );

  fg_err_mon err_i (
    .clk_i, .rst_ni, .hw_clr_i(hw_clr),
    .op_active_i(prog_mode_o || erase_mode_o),
    .evt_i(evt), .abort_o(abort), .err_o(err)
  );

  fg_mode_gate #(.NUM_BLKS(NUM_BLKS)) gate_i (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .err_i(err), .hw_clr_i(hw_clr),
    .mask_i(mask), .prog_mode_o, .erase_mode_o, .erase_stb_o
  );

  assign err_o = err;

  // R1
  hw_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_clr |-> (!prog_mode_o && !erase_mode_o && erase_stb_o == '0));
  // R7
  err_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!prog_mode_o && !erase_mode_o));
  // R4
  modes_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prog_mode_o && erase_mode_o));
endmodule

// File: tb/flash_guard_tb_top.sv
`timescale 1ns/1ps
module flash_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wdt = 1'b0, stby = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  ev = '0;
  logic        pm, em, err;
  logic [15:0] stb;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  flash_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wdt_rst_i(wdt), .standby_i(stby),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .flash_rd_i(ev[0]), .exc_start_i(ev[1]), .sleep_i(ev[2]), .bus_rel_i(ev[3]),
    .prog_mode_o(pm), .erase_mode_o(em), .erase_stb_o(stb), .err_o(err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; #1;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse_ev(int i);
    @(negedge clk); ev[i] = 1'b1;
    @(negedge clk); ev = '0; #1;
  endtask

  task automatic hw_clear(bit use_stby);
    @(negedge clk); if (use_stby) stby = 1'b1; else wdt = 1'b1;
    #1;
    chk("R1 modes low during clear", {pm, em, stb}, '0);
    @(negedge clk); stby = 1'b0; wdt = 1'b0; #1;
  endtask

  task automatic chk_all_zero(string req);
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk(req, d, 8'h00);
    end
    chk(req, {pm, em, stb, err}, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [15:0] m;
    #1;
    chk_all_zero("R1 reset state");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk_all_zero("R1 after reset release");

    // R2 R3 R4 sweep of all control values with a full mask
    wr(2, 8'hff); wr(3, 8'hff);
    for (int v = 0; v < 8; v++) begin
      logic ep, ee;
      wr(0, 8'(v));
      ep = v[0] & v[1] & ~v[2];
      ee = v[0] & v[2] & ~v[1];
      rd(0, d);
      chk("R2 ctrl readback", d, 8'(v));
      chk("R3 R4 prog mode", pm, ep);
      chk("R3 R4 erase mode", em, ee);
      chk("R5 strobes follow erase mode", stb, ee ? 16'hffff : 16'h0);
    end

    // R5 one-hot and patterned masks
    for (int b = 0; b <= 17; b++) begin
      m = (b < 16) ? 16'(1 << b) : (b == 16 ? 16'h0000 : 16'ha5c3);
      wr(2, m[7:0]); wr(3, m[15:8]);
      rd(2, d); chk("R2 mask lo readback", d, m[7:0]);
      rd(3, d); chk("R2 mask hi readback", d, m[15:8]);
      wr(0, 8'h05);
      chk("R5 erase strobe pattern", stb, m);
      wr(0, 8'h03);
      chk("R5 no strobe in program mode", stb, 16'h0);
    end

    // R8 events while idle
    wr(2, 8'hff); wr(3, 8'hff);
    for (int i = 0; i < 4; i++) begin
      wr(0, 8'h00); pulse_ev(i);
      chk("R8 idle event ignored", err, 1'b0);
      wr(0, 8'h07); pulse_ev(i);
      chk("R8 both-bits event ignored", err, 1'b0);
      wr(0, 8'h06); pulse_ev(i);
      chk("R8 no-wen event ignored", err, 1'b0);
    end

    // R6 R7 each event during each operation, cleared by both hw paths
    for (int i = 0; i < 4; i++) begin
      for (int op = 0; op < 2; op++) begin
        logic [7:0] cv;
        cv = op ? 8'h05 : 8'h03;
        wr(2, 8'hff); wr(3, 8'hff);
        wr(0, cv);
        chk("R4 mode entered", {pm, em}, op ? 2'b01 : 2'b10);
        pulse_ev(i);
        chk("R6 err set", err, 1'b1);
        rd(1, d); chk("R6 err at addr1 bit7", d, 8'h80);
        chk("R6 modes dropped", {pm, em, stb}, '0);
        rd(0, d); chk("R6 requests cleared", d, 8'h01);
        wr(0, cv);
        chk("R7 blocked after rewrite", {pm, em}, 2'b00);
        wr(1, 8'h00);
        chk("R7 addr1 write ignored", err, 1'b1);
        hw_clear((i + op) % 2 == 1);
        chk_all_zero("R1 clear after error");
      end
    end

    // R1 standby forces modes low while held, then clears
    wr(2, 8'h0f); wr(0, 8'h05);
    chk("R5 strobes before standby", stb, 16'h000f);
    hw_clear(1'b1);
    chk_all_zero("R1 standby clear");

    // R1 asynchronous reset mid-operation
    wr(3, 8'hf0); wr(0, 8'h05);
    #1; rst_n = 1'b0; #1;
    chk_all_zero("R1 async reset");
    @(negedge clk); rst_n = 1'b1; #1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule